// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns one decoded load or store operand into the byte address that the access should use. The decode stage hands it a mode code, the values already read from the register file for the base and the index, the constant field from the instruction, the current program counter, a shift count for the index and the access size. The unit returns the effective address. For the four auto-modifying modes it also returns the updated base value and a write strobe for the register file.

The constant field is used in two ways. In the absolute modes it is the address. In the other modes it is a displacement. Index scaling is done with a shift. Arithmetic wraps modulo 2^AW and raises no fault.

Memory-indirect mode needs two accesses. The unit first issues a pointer read on a valid/ready request channel and then waits for the response. The returned word becomes the effective address. Every other mode completes in one registered step. A request is accepted only when `req_ready_o` is high. The result is presented for exactly one cycle with `addr_valid_o`.

Top module: `agu_top`

## Requirements
- R1: After reset is released, before any request: `req_ready_o`=1, `addr_valid_o`=0, `mem_req_valid_o`=0 and `wb_en_o`=0.
- R2: Mode 0 (absolute) gives address = `imm_i`. Reserved mode codes 10 to 15 behave the same way. Neither asserts `wb_en_o`.
- R3: Mode 1 gives `base_i`+`imm_i`. Mode 2 gives `pc_i`+`imm_i`.
- R4: Mode 3 gives `imm_i`+(`index_i`<<s). Mode 4 gives `base_i`+`imm_i`+(`index_i`<<s). Here s=`scale_i` for values 0 to 4, and any larger `scale_i` is treated as 4.
- R5: `size_i` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R6: Mode 5 (pre-increment) and mode 7 (pre-decrement) give address = `wb_data_o` = `base_i`±size, with `wb_en_o`=1.
- R7: Mode 6 (post-increment) and mode 8 (post-decrement) give address = `base_i`, `wb_data_o` = `base_i`±size, with `wb_en_o`=1.
- R8: `wb_en_o` is high only in the result cycle of modes 5 to 8.
- R9: A request is taken on a clock edge where `req_valid_i`&&`req_ready_o`. For modes other than 9, `addr_valid_o` is high for exactly the next cycle, and `req_ready_o` is low during that cycle.
- R10: Mode 9 (memory-indirect) holds `mem_req_valid_o` high with `mem_req_addr_o`=`base_i`+`imm_i` until `mem_req_ready_i` is seen. The unit then waits for `mem_rsp_valid_i`. In the cycle after the response, `addr_valid_o`=1 and `addr_o`=`mem_rsp_data_i`, with `wb_en_o`=0.
- R11: All address and writeback sums wrap modulo 2^32.
- R12: `mem_rsp_valid_i` is ignored unless the pointer request has already been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Operand request valid |
| req_ready_o | output | 1 | Unit idle, request can be taken |
| mode_i | input | 4 | Addressing mode code |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| imm_i | input | 32 | Instruction constant (address or displacement) |
| pc_i | input | 32 | Current program counter |
| scale_i | input | 3 | Index left-shift count |
| size_i | input | 2 | Access size code |
| addr_valid_o | output | 1 | Effective address valid (one cycle) |
| addr_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Base register write strobe |
| wb_data_o | output | 32 | Updated base value |
| mem_req_valid_o | output | 1 | Pointer read request valid |
| mem_req_ready_i | input | 1 | Pointer read request accepted |
| mem_req_addr_o | output | 32 | Pointer address |
| mem_rsp_valid_i | input | 1 | Pointer data valid |
| mem_rsp_data_i | input | 32 | Pointer data |

## Verification
The table of operands covers every mode code, including a reserved one.

- **Scaling.** Shift counts 0, 2 and 4 and an out-of-range value are used, so a wrong shift or a missing clamp changes the address.
- **Auto-modification.** Pre and post variants are run with different sizes. This separates which value goes to the address and which goes to writeback, and whether the step is added or subtracted.
- **Wrap-around.** Operands near 2^32 and a negative displacement check that the sums wrap.
- **Memory-indirect.** The pointer fetch is stalled while a stray response is presented. This shows that the request is held and the early response is not used.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [3:0] {
    AM_ABS      = 4'd0,
    AM_BASE     = 4'd1,
    AM_PC       = 4'd2,
    AM_ABS_IDX  = 4'd3,
    AM_BASE_IDX = 4'd4,
    AM_PRE_INC  = 4'd5,
    AM_POST_INC = 4'd6,
    AM_PRE_DEC  = 4'd7,
    AM_POST_DEC = 4'd8,
    AM_MEM_IND  = 4'd9
  } agu_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PTR_REQ,
    ST_PTR_WAIT,
    ST_DONE
  } agu_state_e;
endpackage

// File: rtl/agu_scale.sv
module agu_scale #(
  parameter int AW        = 32,
  parameter int SCW       = 3,
  parameter int MAX_SHIFT = 4
) (
  input  logic [AW-1:0]  index_i,
  input  logic [SCW-1:0] scale_i,
  output logic [AW-1:0]  scaled_o
);
  logic [AW-1:0] cand [MAX_SHIFT+1];

  for (genvar g = 0; g <= MAX_SHIFT; g++) begin : g_shift
    assign cand[g] = index_i << g;
  end

  // out-of-range shift counts saturate at the widest scale
  always_comb begin
    if (int'(scale_i) > MAX_SHIFT) scaled_o = cand[MAX_SHIFT];
    else                           scaled_o = cand[scale_i];
  end
endmodule

// File: rtl/agu_automod.sv
module agu_automod #(
  parameter int AW  = 32,
  parameter int SZW = 2
) (
  input  logic [AW-1:0]  base_i,
  input  logic [SZW-1:0] size_i,
  input  logic           dec_i,
  output logic [AW-1:0]  next_o
);
  logic [AW-1:0] step;
  assign step   = AW'(1) << size_i;
  assign next_o = dec_i ? base_i - step : base_i + step;
endmodule

// File: rtl/agu_seq.sv
module agu_seq
  import agu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       indirect_i,
  input  logic       mem_req_ready_i,
  input  logic       mem_rsp_valid_i,
  output agu_state_e state_o,
  output logic       rsp_take_o
);
  agu_state_e state_q, state_d;

  assign rsp_take_o = (state_q == ST_PTR_WAIT) && mem_rsp_valid_i;
  assign state_o    = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (accept_i) state_d = indirect_i ? ST_PTR_REQ : ST_DONE;
      ST_PTR_REQ:  if (mem_req_ready_i) state_d = ST_PTR_WAIT;
      ST_PTR_WAIT: if (mem_rsp_valid_i) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SCW       = 3,
  parameter int SZW       = 2,
  parameter int MAX_SHIFT = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic [3:0]     mode_i,
  input  logic [AW-1:0]  base_i,
  input  logic [AW-1:0]  index_i,
  input  logic [AW-1:0]  imm_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [SCW-1:0] scale_i,
  input  logic [SZW-1:0] size_i,
  output logic           addr_valid_o,
  output logic [AW-1:0]  addr_o,
  output logic           wb_en_o,
  output logic [AW-1:0]  wb_data_o,
  output logic           mem_req_valid_o,
  input  logic           mem_req_ready_i,
  output logic [AW-1:0]  mem_req_addr_o,
  input  logic           mem_rsp_valid_i,
  input  logic [AW-1:0]  mem_rsp_data_i
);
  agu_state_e    state;
  logic          accept, rsp_take, is_ind, is_dec, calc_wb_en;
  logic [AW-1:0] scaled, mod_val, calc_ea;
  logic [AW-1:0] ea_q, wb_q;
  logic          wb_en_q;

  agu_scale #(.AW(AW), .SCW(SCW), .MAX_SHIFT(MAX_SHIFT)) u_scale (
    .index_i (index_i),
    .scale_i (scale_i),
    .scaled_o(scaled)
  );

  assign is_dec = (mode_i == AM_PRE_DEC) || (mode_i == AM_POST_DEC);

  agu_automod #(.AW(AW), .SZW(SZW)) u_automod (
    .base_i(base_i),
    .size_i(size_i),
    .dec_i (is_dec),
    .next_o(mod_val)
  );

  always_comb begin
    calc_wb_en = 1'b0;
    is_ind     = 1'b0;
    case (mode_i)
      AM_BASE:     calc_ea = base_i + imm_i;
      AM_PC:       calc_ea = pc_i + imm_i;
      AM_ABS_IDX:  calc_ea = imm_i + scaled;
      AM_BASE_IDX: calc_ea = base_i + imm_i + scaled;
      AM_PRE_INC, AM_PRE_DEC: begin
        calc_ea    = mod_val;
        calc_wb_en = 1'b1;
      end
      AM_POST_INC, AM_POST_DEC: begin
        calc_ea    = base_i;
        calc_wb_en = 1'b1;
      end
      AM_MEM_IND: begin
        calc_ea = base_i + imm_i;  // pointer location
        is_ind  = 1'b1;
      end
      default:     calc_ea = imm_i;  // absolute and reserved codes
    endcase
  end

  assign accept = req_valid_i && req_ready_o;

  agu_seq u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .accept_i       (accept),
    .indirect_i     (is_ind),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .state_o        (state),
    .rsp_take_o     (rsp_take)
  );

  // ea_q holds the pointer address during the fetch, then the fetched pointer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q    <= '0;
      wb_q    <= '0;
      wb_en_q <= 1'b0;
    end else if (accept) begin
      ea_q    <= calc_ea;
      wb_q    <= mod_val;
      wb_en_q <= calc_wb_en;
    end else if (rsp_take) begin
      ea_q    <= mem_rsp_data_i;
    end
  end

  assign req_ready_o     = (state == ST_IDLE);
  assign addr_valid_o    = (state == ST_DONE);
  assign addr_o          = ea_q;
  assign wb_en_o         = addr_valid_o && wb_en_q;
  assign wb_data_o       = wb_q;
  assign mem_req_valid_o = (state == ST_PTR_REQ);
  assign mem_req_addr_o  = ea_q;
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int AW  = 32,
  parameter int SCW = 3,
  parameter int SZW = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic [3:0]     mode_i,
  input logic [AW-1:0]  base_i,
  input logic [AW-1:0]  imm_i,
  input logic [SZW-1:0] size_i,
  input logic           addr_valid_o,
  input logic [AW-1:0]  addr_o,
  input logic           wb_en_o,
  input logic [AW-1:0]  wb_data_o,
  input logic           mem_req_valid_o,
  input logic           mem_req_ready_i,
  input logic [AW-1:0]  mem_req_addr_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  p_abs_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && mode_i == 4'd0 |=> addr_valid_o && !wb_en_o && addr_o == $past(imm_i));

  p_post_inc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && mode_i == 4'd6 |=> addr_valid_o && wb_en_o && addr_o == $past(base_i)
      && wb_data_o == $past(base_i) + (AW'(1) << $past(size_i)));

  p_wb_in_result_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> addr_valid_o);

  p_direct_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && mode_i != 4'd9 |=> addr_valid_o && !req_ready_o);

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |=> !addr_valid_o && req_ready_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !addr_valid_o && !mem_req_valid_o);

  p_ptr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  p_ptr_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && mode_i == 4'd9 |=> mem_req_valid_o && mem_req_addr_o == $past(base_i) + $past(imm_i));
endmodule

bind agu_top agu_chk #(.AW(AW), .SCW(SCW), .SZW(SZW)) u_agu_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .mode_i         (mode_i),
  .base_i         (base_i),
  .imm_i          (imm_i),
  .size_i         (size_i),
  .addr_valid_o   (addr_valid_o),
  .addr_o         (addr_o),
  .wb_en_o        (wb_en_o),
  .wb_data_o      (wb_data_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o (mem_req_addr_o)
);

// File: tb/tb_agu_top.sv
`timescale 1ns/1ps
module tb_agu_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [3:0]  mode_i = '0;
  logic [31:0] base_i = '0, index_i = '0, imm_i = '0, pc_i = '0;
  logic [2:0]  scale_i = '0;
  logic [1:0]  size_i = '0;
  logic        addr_valid_o, wb_en_o, mem_req_valid_o;
  logic [31:0] addr_o, wb_data_o, mem_req_addr_o;
  logic        mem_req_ready_i = 1'b0;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  agu_top dut (.*);

  typedef struct packed {
    logic [3:0]  mode;
    logic [31:0] base;
    logic [31:0] idx;
    logic [31:0] imm;
    logic [31:0] pc;
    logic [2:0]  scale;
    logic [1:0]  size;
    logic [31:0] exp_addr;
    logic        exp_wb_en;
    logic [31:0] exp_wb;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  32'h0,        32'h0,  32'h1000_0040, 32'h0,   3'd0, 2'd0, 32'h1000_0040, 1'b0, 32'h0},        // R2
    '{4'd12, 32'h99,       32'h5,  32'h77,        32'h0,   3'd1, 2'd0, 32'h77,        1'b0, 32'h0},        // R2 reserved
    '{4'd1,  32'h2000,     32'h0,  32'h10,        32'h0,   3'd0, 2'd0, 32'h2010,      1'b0, 32'h0},        // R3
    '{4'd1,  32'h2000,     32'h0,  32'hFFFF_FFF0, 32'h0,   3'd0, 2'd0, 32'h1FF0,      1'b0, 32'h0},        // R3 R11
    '{4'd2,  32'h5000,     32'h0,  32'h24,        32'h400, 3'd0, 2'd0, 32'h424,       1'b0, 32'h0},        // R3 pc
    '{4'd3,  32'h0,        32'h3,  32'h8000,      32'h0,   3'd2, 2'd0, 32'h800C,      1'b0, 32'h0},        // R4
    '{4'd4,  32'h100,      32'h5,  32'h4,         32'h0,   3'd4, 2'd0, 32'h154,       1'b0, 32'h0},        // R4 x16
    '{4'd4,  32'h10,       32'h7,  32'h0,         32'h0,   3'd0, 2'd0, 32'h17,        1'b0, 32'h0},        // R4 x1
    '{4'd3,  32'h0,        32'h1,  32'h0,         32'h0,   3'd7, 2'd0, 32'h10,        1'b0, 32'h0},        // R4 clamp
    '{4'd4,  32'hFFFF_FFF0,32'h10, 32'h0,         32'h0,   3'd1, 2'd0, 32'h10,        1'b0, 32'h0},        // R11
    '{4'd7,  32'h1000,     32'h0,  32'h0,         32'h0,   3'd0, 2'd2, 32'hFFC,       1'b1, 32'hFFC},      // R6 push
    '{4'd6,  32'hFFC,      32'h0,  32'h0,         32'h0,   3'd0, 2'd2, 32'hFFC,       1'b1, 32'h1000},     // R7 pop
    '{4'd5,  32'h20,       32'h0,  32'h0,         32'h0,   3'd0, 2'd3, 32'h28,        1'b1, 32'h28},       // R6 R5
    '{4'd8,  32'h20,       32'h0,  32'h0,         32'h0,   3'd0, 2'd0, 32'h20,        1'b1, 32'h1F},       // R7 R5
    '{4'd6,  32'hFFFF_FFFF,32'h0,  32'h0,         32'h0,   3'd0, 2'd1, 32'hFFFF_FFFF, 1'b1, 32'h1},        // R7 R11
    '{4'd7,  32'h0,        32'h0,  32'h0,         32'h0,   3'd0, 2'd1, 32'hFFFF_FFFE, 1'b1, 32'hFFFF_FFFE} // R6 R11
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(req_ready_o == 1'b1,     "R1", "ready",     32'(req_ready_o), 32'd1);
    chk(addr_valid_o == 1'b0,    "R1", "valid",     32'(addr_valid_o), 32'd0);
    chk(mem_req_valid_o == 1'b0, "R1", "mem_req",   32'(mem_req_valid_o), 32'd0);
    chk(wb_en_o == 1'b0,         "R1", "wb_en",     32'(wb_en_o), 32'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      mode_i = VEC[i].mode; base_i = VEC[i].base; index_i = VEC[i].idx;
      imm_i = VEC[i].imm; pc_i = VEC[i].pc; scale_i = VEC[i].scale; size_i = VEC[i].size;
      req_valid_i = 1'b1;
      @(negedge clk_i);
      req_valid_i = 1'b0;
      chk(addr_valid_o == 1'b1, "R9", $sformatf("vec%0d valid", i), 32'(addr_valid_o), 32'd1);
      chk(req_ready_o == 1'b0,  "R9", $sformatf("vec%0d busy", i),  32'(req_ready_o), 32'd0);
      chk(addr_o == VEC[i].exp_addr, "R2-R7", $sformatf("vec%0d addr", i), addr_o, VEC[i].exp_addr);
      chk(wb_en_o == VEC[i].exp_wb_en, "R8", $sformatf("vec%0d wb_en", i), 32'(wb_en_o), 32'(VEC[i].exp_wb_en));
      if (VEC[i].exp_wb_en)
        chk(wb_data_o == VEC[i].exp_wb, "R6/R7", $sformatf("vec%0d wb", i), wb_data_o, VEC[i].exp_wb);
      @(negedge clk_i);
      chk(addr_valid_o == 1'b0 && req_ready_o == 1'b1, "R9", $sformatf("vec%0d pulse", i),
          {30'd0, addr_valid_o, req_ready_o}, 32'd1);
    end

    // R10 R12 memory-indirect with stalled request and stray response
    mode_i = 4'd9; base_i = 32'h3000; imm_i = 32'h8; size_i = 2'd2;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(mem_req_valid_o == 1'b1, "R10", "ptr req", 32'(mem_req_valid_o), 32'd1);
    chk(mem_req_addr_o == 32'h3008, "R10", "ptr addr", mem_req_addr_o, 32'h3008);
    mem_rsp_valid_i = 1'b1; mem_rsp_data_i = 32'hDEAD_0000;  // R12 stray
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0;
    chk(mem_req_valid_o == 1'b1 && addr_valid_o == 1'b0, "R12", "req held",
        {30'd0, mem_req_valid_o, addr_valid_o}, 32'd2);
    chk(mem_req_addr_o == 32'h3008, "R10", "addr held", mem_req_addr_o, 32'h3008);
    mem_req_ready_i = 1'b1;
    @(negedge clk_i);
    mem_req_ready_i = 1'b0;
    chk(mem_req_valid_o == 1'b0 && addr_valid_o == 1'b0, "R10", "wait",
        {30'd0, mem_req_valid_o, addr_valid_o}, 32'd0);
    @(negedge clk_i);
    chk(addr_valid_o == 1'b0, "R10", "still waiting", 32'(addr_valid_o), 32'd0);
    mem_rsp_valid_i = 1'b1; mem_rsp_data_i = 32'h0004_5670;
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0;
    chk(addr_valid_o == 1'b1, "R10", "ind valid", 32'(addr_valid_o), 32'd1);
    chk(addr_o == 32'h0004_5670, "R10", "ind addr", addr_o, 32'h0004_5670);
    chk(wb_en_o == 1'b0, "R8", "ind wb_en", 32'(wb_en_o), 32'd0);
    @(negedge clk_i);
    chk(req_ready_o == 1'b1 && addr_valid_o == 1'b0, "R9", "ind end",
        {30'd0, req_ready_o, addr_valid_o}, 32'd2);

    // R12 response while idle has no effect on next absolute result
    mem_rsp_valid_i = 1'b1; mem_rsp_data_i = 32'hBAD0_BAD0;
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0;
    chk(addr_valid_o == 1'b0 && req_ready_o == 1'b1, "R12", "idle rsp",
        {30'd0, addr_valid_o, req_ready_o}, 32'd1);
    mode_i = 4'd0; imm_i = 32'h0000_1234;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(addr_o == 32'h0000_1234, "R12", "after idle rsp", addr_o, 32'h0000_1234);
    @(negedge clk_i);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule